// File: doc/BRIEF.md
# Mesh Packet Receiver with Memory Copy Engine

This block sits between a mesh router's output port and a local processing element. It takes 64-bit flits on a valid/ready stream and decodes each head flit. The type byte, the 16-bit tag and the 32-bit payload are stored in receive registers, which the processor reads over a simple register port. An interrupt tells the processor that a packet is waiting. The flit stream is then held off until the processor finishes with that packet.

There are three kinds of packet.

- **Single packet:** it carries its whole payload in the head flit. It is released when the processor reads the payload register.
- **Block packet:** the low 16 bits of the payload give the number of body flits. The block waits until the processor writes a memory start address. It then copies each body flit into local memory at successive word addresses and drops the interrupt on the last write.
- **Instruction packet:** it is never shown to the processor. Its tag names one of the node's send registers and its payload is the value for that register. The value goes out on an update port toward the packet builder, so a remote node can, for example, redirect this node's results.

Top module: `noc_rx_unpacker`

## Requirements
- R1: Head flit layout: bits 63:56 are the type byte, bits 55:48 the route, bits 47:32 the tag and bits 31:0 the payload. Type bits 57:56 select the kind: 2'b10 is a block packet, 2'b11 is an instruction, and any other value is a single packet. On acceptance of a single or block head, a read at offset 0x20 returns the type byte, at 0x24 the tag and at 0x28 the payload, each zero-extended to 32 bits.
- R2: The interrupt rises on the clock edge that accepts a single or block head, the same edge that loads the receive registers.
- R3: flit_ready is high when idle and while block body flits are being copied. It is low while a single packet waits for its payload read and while a block packet waits for its start address.
- R4: For a pending single packet, a read of offset 0x28 clears the interrupt and raises flit_ready on the next edge. Reads of the type and tag offsets do not release the packet.
- R5: For a block packet the flit count is payload bits 15:0. No memory write occurs before the processor writes the start address to offset 0x2C.
- R6: Body flit k (counting from 0) is written whole to address start+k. mem_we is high in the cycle after that flit is accepted. The interrupt stays high until the last body write and clears in the same cycle as that write.
- R7: A block packet with a count of zero completes on the start-address write. It makes no memory write and clears the interrupt.
- R8: An instruction head with tag below SEND_REGS (default 6) gives upd_valid for one cycle after acceptance, with upd_sel equal to tag bits 7:0 and upd_value equal to the payload. It raises no interrupt and leaves the receive registers unchanged.
- R9: An instruction head whose tag is SEND_REGS or larger produces no update pulse and no interrupt.
- R10: After reset: interrupt low, flit_ready high, no memory write, no update pulse, and receive registers reading zero.
- R11: Reads of offset 0x2C or of any unmapped offset return zero. Writes to the read-only offsets 0x20, 0x24 and 0x28 have no effect. A start-address write while no block packet is waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_valid | input | 1 | Flit present on flit_data |
| flit_data | input | 64 | Incoming flit |
| flit_ready | output | 1 | Flit accepted on an edge where valid and ready are both high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational while reg_rd is high |
| irq | output | 1 | Packet waiting for the processor |
| mem_we | output | 1 | Local memory write enable |
| mem_addr | output | ADDR_W | Local memory word address |
| mem_wdata | output | 64 | Local memory write data |
| upd_valid | output | 1 | Send-register update pulse |
| upd_sel | output | OPC_W | Send register selected by the instruction |
| upd_value | output | 32 | Value for the selected send register |

## Verification
The bench mixes random single, block and instruction packets with directed corner cases.

- **Single packets** use random type bytes whose low two bits avoid the block and instruction codes. They show that the fields are sliced at the right bit positions, and that only the payload read releases the packet.
- **Block packets** use random lengths from one to six, random start addresses and random upper payload bits. They show that the count comes only from bits 15:0, that memory stays untouched until the address arrives, and that the interrupt drops exactly on the final write.
- **Instruction packets** use tags on both sides of the SEND_REGS limit. They separate the forwarded case from the dropped one, and a payload read-back shows that neither disturbs the stored receive registers.
- **Directed cases** cover a zero-length block, a stray address write, writes to read-only offsets and unmapped reads.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    localparam int FLIT_W = 64;
    localparam int REG_W  = 32;

    localparam logic [7:0] OFS_TYPE  = 8'h20;
    localparam logic [7:0] OFS_TAG   = 8'h24;
    localparam logic [7:0] OFS_DATA  = 8'h28;
    localparam logic [7:0] OFS_START = 8'h2C;

    typedef enum logic [1:0] {
        K_SINGLE,
        K_BLOCK,
        K_INSTR
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_WAITA,
        ST_STREAM
    } st_e;

    typedef struct packed {
        logic [7:0]  ptype;
        logic [7:0]  route;
        logic [15:0] tag;
        logic [31:0] payload;
    } head_t;

    function automatic kind_e kind_of(input logic [7:0] t);
        case (t[1:0])
            2'b10:   return K_BLOCK;
            2'b11:   return K_INSTR;
            default: return K_SINGLE;
        endcase
    endfunction

endpackage

// File: rtl/rxu_rx_regs.sv
module rxu_rx_regs
    import rxu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  head_t       hd,
    output logic [7:0]  type_q,
    output logic [15:0] tag_q,
    output logic [31:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            type_q <= '0;
            tag_q  <= '0;
            data_q <= '0;
        end else if (load) begin
            type_q <= hd.ptype;
            tag_q  <= hd.tag;
            data_q <= hd.payload;
        end
    end
endmodule

// File: rtl/rxu_instr.sv
module rxu_instr
    import rxu_pkg::*;
#(
    parameter int OPC_W     = 8,
    parameter int SEND_REGS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  head_t            hd,
    output logic             upd_valid,
    output logic [OPC_W-1:0] upd_sel,
    output logic [31:0]      upd_value
);
    logic in_range;
    assign in_range = (hd.tag < 16'(SEND_REGS));

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_valid <= 1'b0;
            upd_sel   <= '0;
            upd_value <= '0;
        end else begin
            upd_valid <= fire && in_range;
            if (fire && in_range) begin
                upd_sel   <= hd.tag[OPC_W-1:0];
                upd_value <= hd.payload;
            end
        end
    end
endmodule

// File: rtl/rxu_dma.sv
module rxu_dma
    import rxu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [CNT_W-1:0]  arm_cnt,
    input  logic              beat,
    input  logic [FLIT_W-1:0] beat_data,
    output logic              last,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [FLIT_W-1:0] mem_wdata
);
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  remain;

    assign last = (remain == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            remain    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= beat;
            if (arm) begin
                ptr    <= arm_addr;
                remain <= arm_cnt;
            end else if (beat) begin
                mem_addr  <= ptr;
                mem_wdata <= beat_data;
                ptr       <= ptr + ADDR_W'(1);
                remain    <= remain - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/rxu_ctrl.sv
module rxu_ctrl
    import rxu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flit_valid,
    input  kind_e kind,
    input  logic  cnt_zero,
    input  logic  data_rd,
    input  logic  addr_wr,
    input  logic  beat_last,
    output st_e   st,
    output logic  irq,
    output logic  flit_ready,
    output logic  head_fire,
    output logic  beat,
    output logic  arm
);
    assign flit_ready = (st == ST_IDLE) || (st == ST_STREAM);
    assign head_fire  = flit_valid && (st == ST_IDLE);
    assign beat       = flit_valid && (st == ST_STREAM);
    assign arm        = addr_wr && (st == ST_WAITA) && !cnt_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            irq <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (head_fire) begin
                    if (kind == K_SINGLE) begin
                        st  <= ST_HOLD;
                        irq <= 1'b1;
                    end else if (kind == K_BLOCK) begin
                        st  <= ST_WAITA;
                        irq <= 1'b1;
                    end
                end
                ST_HOLD: if (data_rd) begin
                    st  <= ST_IDLE;
                    irq <= 1'b0;
                end
                ST_WAITA: if (addr_wr) begin
                    if (cnt_zero) begin
                        st  <= ST_IDLE;
                        irq <= 1'b0;
                    end else begin
                        st <= ST_STREAM;
                    end
                end
                ST_STREAM: if (beat && beat_last) begin
                    st  <= ST_IDLE;
                    irq <= 1'b0;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/noc_rx_unpacker.sv
module noc_rx_unpacker
    import rxu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int OPC_W     = 8,
    parameter int SEND_REGS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flit_valid,
    input  logic [63:0]       flit_data,
    output logic              flit_ready,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    output logic              upd_valid,
    output logic [OPC_W-1:0]  upd_sel,
    output logic [31:0]       upd_value
);
    head_t       hd;
    kind_e       kind;
    st_e         st;
    logic        head_fire, beat, arm, last;
    logic [7:0]  type_q;
    logic [15:0] tag_q;
    logic [31:0] data_q;
    logic        data_rd, addr_wr, load, fire_instr;

    assign hd         = head_t'(flit_data);
    assign kind       = kind_of(hd.ptype);
    assign load       = head_fire && (kind != K_INSTR);
    assign fire_instr = head_fire && (kind == K_INSTR);
    assign data_rd    = reg_rd && (reg_addr == OFS_DATA);
    assign addr_wr    = reg_wr && (reg_addr == OFS_START);

    rxu_ctrl u_ctrl (
        .clk(clk), .rst(rst), .flit_valid(flit_valid), .kind(kind),
        .cnt_zero(data_q[CNT_W-1:0] == '0), .data_rd(data_rd),
        .addr_wr(addr_wr), .beat_last(last), .st(st), .irq(irq),
        .flit_ready(flit_ready), .head_fire(head_fire), .beat(beat), .arm(arm)
    );

    rxu_rx_regs u_regs (
        .clk(clk), .rst(rst), .load(load), .hd(hd),
        .type_q(type_q), .tag_q(tag_q), .data_q(data_q)
    );

    rxu_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dma (
        .clk(clk), .rst(rst), .arm(arm), .arm_addr(reg_wdata[ADDR_W-1:0]),
        .arm_cnt(data_q[CNT_W-1:0]), .beat(beat), .beat_data(flit_data),
        .last(last), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    rxu_instr #(.OPC_W(OPC_W), .SEND_REGS(SEND_REGS)) u_instr (
        .clk(clk), .rst(rst), .fire(fire_instr), .hd(hd),
        .upd_valid(upd_valid), .upd_sel(upd_sel), .upd_value(upd_value)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFS_TYPE: reg_rdata = {24'b0, type_q};
                OFS_TAG:  reg_rdata = {16'b0, tag_q};
                OFS_DATA: reg_rdata = data_q;
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rxu_checker.sv
module rxu_checker
    import rxu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input st_e               st,
    input logic              flit_valid,
    input logic [63:0]       flit_data,
    input logic              flit_ready,
    input logic              reg_rd,
    input logic [7:0]        reg_addr,
    input logic              irq,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    logic head_acc;
    assign head_acc = flit_valid && flit_ready && (st == ST_IDLE);

    assert_pending_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD || st == ST_WAITA) |-> !flit_ready);

    assert_irq_on_head_R2: assert property (@(posedge clk) disable iff (rst)
        (head_acc && flit_data[57:56] != 2'b11) |=> irq);

    assert_single_release_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && reg_rd && reg_addr == OFS_DATA) |=> (!irq && flit_ready));

    assert_no_early_write_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAITA) |-> !mem_we);

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + {{(ADDR_W-1){1'b0}}, 1'b1}));

    assert_instr_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (head_acc && flit_data[57:56] == 2'b11) |=> !irq);
endmodule

bind noc_rx_unpacker rxu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .st(st), .flit_valid(flit_valid), .flit_data(flit_data),
    .flit_ready(flit_ready), .reg_rd(reg_rd), .reg_addr(reg_addr), .irq(irq),
    .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/noc_rx_unpacker_bench.sv
module noc_rx_unpacker_bench;
    localparam int SEND_REGS = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flit_valid = 1'b0;
    logic [63:0] flit_data = '0;
    logic        flit_ready;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_we, upd_valid;
    logic [31:0] mem_addr, upd_value;
    logic [63:0] mem_wdata;
    logic [7:0]  upd_sel;

    int checks = 0, fails = 0;
    int mcnt = 0, ucnt = 0;
    logic [31:0] mlog_a [0:255];
    logic [63:0] mlog_d [0:255];
    logic [7:0]  u_sel_last;
    logic [31:0] u_val_last;
    logic [31:0] last_data = '0;

    always #5 clk = ~clk;

    noc_rx_unpacker u_noc_rx_unpacker (
        .clk(clk), .rst(rst), .flit_valid(flit_valid), .flit_data(flit_data),
        .flit_ready(flit_ready), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .upd_valid(upd_valid),
        .upd_sel(upd_sel), .upd_value(upd_value)
    );

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (mcnt < 256) begin
                mlog_a[mcnt] = mem_addr;
                mlog_d[mcnt] = mem_wdata;
            end
            mcnt = mcnt + 1;
        end
        if (!rst && upd_valid) begin
            u_sel_last = upd_sel;
            u_val_last = upd_value;
            ucnt = ucnt + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] mk_head(input logic [7:0] t, input logic [15:0] tag, input logic [31:0] d);
        return {t, 8'h21, tag, d};
    endfunction

    function automatic logic [7:0] single_type(input logic [7:0] r);
        return r & 8'hFD;
    endfunction

    task automatic push(input logic [63:0] f);
        flit_valid = 1'b1;
        flit_data  = f;
        while (!flit_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        flit_valid = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic do_single(input logic [7:0] t, input logic [15:0] tag, input logic [31:0] d);
        logic [31:0] v;
        push(mk_head(t, tag, d));
        check("R2 irq after head", irq, 1);
        check("R3 ready low while held", flit_ready, 0);
        rd(8'h20, v); check("R1 type", v, {24'b0, t});
        rd(8'h24, v); check("R1 tag", v, {16'b0, tag});
        check("R4 irq kept after tag read", irq, 1);
        rd(8'h28, v); check("R1 data", v, d);
        check("R4 irq clears", irq, 0);
        check("R4 ready back", flit_ready, 1);
        last_data = d;
    endtask

    task automatic do_block(input int n, input logic [31:0] start, input logic [15:0] hi);
        logic [63:0] body [0:15];
        int base;
        logic [31:0] d;
        d = {hi, 16'(n)};
        base = mcnt;
        push(mk_head(8'h02, 16'h0BB0, d));
        check("R2 irq after block head", irq, 1);
        repeat (3) @(negedge clk);
        #1;
        check("R5 no write before address", mcnt, base);
        check("R3 ready low awaiting address", flit_ready, 0);
        wr(8'h2C, start);
        for (int i = 0; i < n; i++) begin
            body[i] = {$urandom, $urandom};
            push(body[i]);
            check("R6 write one cycle after accept", mcnt, base + i + 1);
            if (i < n - 1) check("R6 irq held mid-block", irq, 1);
        end
        check("R6 irq clears at last write", irq, 0);
        check("R7/R6 write count", mcnt, base + n);
        for (int i = 0; i < n; i++) begin
            check("R6 address", mlog_a[base+i], start + 32'(i));
            check("R6 data", mlog_d[base+i], body[i]);
        end
        last_data = d;
    endtask

    task automatic do_instr(input logic [15:0] opc, input logic [31:0] val);
        int u0;
        logic [31:0] v;
        u0 = ucnt;
        push(mk_head(8'h03, opc, val));
        check("R8 no irq for instruction", irq, 0);
        if (opc < 16'(SEND_REGS)) begin
            check("R8 update pulse", ucnt, u0 + 1);
            check("R8 update select", u_sel_last, opc[7:0]);
            check("R8 update value", u_val_last, val);
        end else begin
            check("R9 no update pulse", ucnt, u0);
        end
        rd(8'h28, v);
        check("R8 receive regs unchanged", v, last_data);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 irq reset", irq, 0);
        check("R10 ready reset", flit_ready, 1);
        check("R10 no mem write", mcnt, 0);
        check("R10 no update", ucnt, 0);
        rd(8'h28, v); check("R10 data reg zero", v, 0);
        rd(8'h20, v); check("R10 type reg zero", v, 0);

        do_single(8'h41, 16'hBEEF, 32'hCAFE_0001);
        wr(8'h28, 32'h1234_5678);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R11 write to data ignored", v, 32'hCAFE_0001);
        rd(8'h20, v); check("R11 write to type ignored", v, 32'h41);
        rd(8'h2C, v); check("R11 start offset reads zero", v, 0);
        rd(8'h10, v); check("R11 unmapped reads zero", v, 0);
        wr(8'h2C, 32'h100);
        check("R11 stray start write ignored", flit_ready, 1);
        check("R11 stray start no write", mcnt, 0);

        begin
            int b;
            logic [31:0] d0;
            b = mcnt;
            d0 = 32'hABCD_0000;
            push(mk_head(8'h06, 16'h0001, d0));
            check("R7 irq on empty block", irq, 1);
            wr(8'h2C, 32'h200);
            check("R7 empty block done", irq, 0);
            check("R7 empty block ready", flit_ready, 1);
            repeat (2) @(negedge clk);
            #1;
            check("R7 empty block no write", mcnt, b);
            last_data = d0;
        end

        do_block(1, 32'h0000_1000, 16'hFFFF);
        do_instr(16'd0, 32'h0000_0011);
        do_instr(16'd5, 32'h5555_AAAA);
        do_instr(16'd6, 32'h6666_0000);
        do_instr(16'h0100, 32'h1);

        for (int it = 0; it < 40; it++) begin
            int k;
            k = $urandom % 3;
            if (k == 0)
                do_single(single_type(8'($urandom)), 16'($urandom), $urandom);
            else if (k == 1)
                do_block(1 + ($urandom % 6), $urandom & 32'hFFFF_F000, 16'($urandom));
            else
                do_instr(16'($urandom % 9), $urandom);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule